// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns requests for inter-processor interrupts into per-CPU pending state. A CPU writes a generate word that names one of 16 interrupt numbers, a list of destination CPUs and a filter. The filter can keep the list as written, replace it with every online CPU other than the requester, or replace it with the requester alone. Each destination then marks that interrupt pending and sets the requester's bit in an 8-bit source byte. One byte is kept for every pair of destination CPU and interrupt number, so requests from different senders stay apart.

Software can also work directly on the source bytes of one chosen CPU's bank. It can OR bits in through a set port and remove them through a clear port, using 8-bit or 32-bit accesses. Both ports read back the bytes. A pending output for each CPU and interrupt number goes to the downstream prioritisation logic. The number of online CPUs is an input, and destinations at or above that count are dropped.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every pending output is low and every source byte reads as zero.
- R2: A generate write carries the interrupt number in bits [3:0], the destination list in bits [23:16] (bit n = CPU n) and the filter in bits [25:24]. With filter 0, every listed online CPU shows that interrupt pending on the clock edge that takes the write, with the requester's bit set in its source byte.
- R3: Filter 1 sends to every online CPU except the requester and ignores the list. The requester's own pending state is left unchanged.
- R4: Filter 2 sends only to the requester and ignores the list.
- R5: Filter 3 is reserved. Such a write changes no pending flag and no source byte.
- R6: Destination bits at or above the online CPU count (1 to 8) are ignored.
- R7: A set-port write ORs each written byte into the addressed source byte. The flag rises only when the resulting byte is nonzero, so a zero byte leaves an interrupt untouched.
- R8: A clear-port write removes the written bits from the source byte. The flag drops only when no source bit remains.
- R9: Byte lane i of an access maps to interrupt (offset + i) mod 16. Wide accesses (pnd_wide=1) cover lanes 0 to 3. Narrow accesses cover lane 0 only and read zero in lanes 1 to 3. Reads return the addressed source bytes of the bank pnd_cpu selects.
- R10: When a generate write and a pending-port write land in the same cycle, the pending-port write is applied first and the generate write is merged on top of it.
- R11: Requests from different senders to the same interrupt set separate bits of one source byte.
- R12: A pending-port write changes only the bank of the CPU that pnd_cpu selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| online_cnt | input | 4 | Number of online CPUs, 1 to 8 |
| gen_we | input | 1 | Generate-word write strobe |
| gen_cpu | input | 3 | Index of the requesting CPU |
| gen_word | input | 32 | Generate word: number, destination list, filter |
| pnd_we | input | 1 | Pending-port write strobe |
| pnd_set | input | 1 | 1 selects the set port, 0 selects the clear port |
| pnd_wide | input | 1 | 1 selects a 32-bit access, 0 an 8-bit access |
| pnd_cpu | input | 3 | CPU bank accessed through the pending port |
| pnd_addr | input | 4 | Byte offset, which is the first interrupt number |
| pnd_wdata | input | 32 | Pending-port write data, one byte per lane |
| pnd_rdata | output | 32 | Source bytes of the addressed interrupts |
| pend_o | output | 128 | Pending flags, bit c*16+s for CPU c and interrupt s |

## Verification
The hardest case to reach is a single source byte that holds bits from several senders, followed by partial clears. The flag must stay high until the last bit goes. The stimulus builds this byte with two generate writes from different requesters that use different filters. It then clears one sender's bit and then the other's, and samples the flag and the read-back after each step. The same-cycle collision of a generate write with a clear to the same byte is forced by driving both strobes on one edge, after first preloading the byte through the set port. A 32-bit access at offset 14 covers the wrap from interrupt 15 back to 0.

// File: rtl/sgi_pkg.sv
// Shared definitions for the software-generated interrupt dispatcher.
// Assumes a 32-bit generate word with the fixed field positions below.
package sgi_pkg;
    localparam int GEN_ID_LSB   = 0;
    localparam int GEN_LIST_LSB = 16;
    localparam int GEN_FLT_LSB  = 24;
    localparam int SRC_W        = 8;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;
endpackage

// File: rtl/sgi_target_decode.sv
// Decodes a generate word into a destination CPU mask and an interrupt number.
// Assumes NUM_CPU <= 8 and an online count from 1 to NUM_CPU.
module sgi_target_decode #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CW  = $clog2(NUM_CPU),
    localparam int CNW = CW + 1,
    localparam int AW  = $clog2(NUM_SGI)
) (
    input  logic [31:0]        gen_word,
    input  logic [CW-1:0]      req_cpu,
    input  logic [CNW-1:0]     online_cnt,
    output logic [NUM_CPU-1:0] targets,
    output logic [AW-1:0]      sgi_id
);
    import sgi_pkg::*;

    logic [NUM_CPU-1:0] online_mask;
    logic [NUM_CPU-1:0] self_bit;
    logic [NUM_CPU-1:0] list;
    sgi_filter_e        flt;
    logic               unused_bits;

    // Online mask: one bit per CPU below the runtime count.
    always_comb begin
        for (int i = 0; i < NUM_CPU; i++) begin
            online_mask[i] = (CNW'(i) < online_cnt);
        end
    end

    assign self_bit    = NUM_CPU'(1) << req_cpu;
    assign list        = gen_word[GEN_LIST_LSB +: NUM_CPU];
    assign flt         = sgi_filter_e'(gen_word[GEN_FLT_LSB +: 2]);
    assign sgi_id      = gen_word[GEN_ID_LSB +: AW];
    assign unused_bits = ^gen_word;

    // Filter selection: apply the mode to the written list.
    always_comb begin
        case (flt)
            FLT_LIST:   targets = list & online_mask;
            FLT_OTHERS: targets = online_mask & ~self_bit;
            FLT_SELF:   targets = self_bit & online_mask;
            default:    targets = '0;
        endcase
    end
endmodule

// File: rtl/sgi_lane_map.sv
// Maps byte lanes of a pending-port access to interrupt numbers.
// Lane l covers interrupt (addr + l) mod NUM_SGI. Narrow accesses use lane 0.
module sgi_lane_map #(
    parameter int NUM_SGI = 16,
    parameter int LANES   = 4,
    localparam int AW = $clog2(NUM_SGI),
    localparam int DW = 8 * LANES
) (
    input  logic [AW-1:0]             addr,
    input  logic                      wide,
    input  logic [DW-1:0]             wdata,
    input  logic [NUM_SGI-1:0][7:0]   rd_bank,
    output logic [NUM_SGI-1:0][7:0]   wr_bytes,
    output logic [DW-1:0]             rdata
);
    logic [AW-1:0] s;

    // Spread write lanes onto interrupts and gather read lanes from them.
    always_comb begin
        wr_bytes = '0;
        rdata    = '0;
        s        = '0;
        for (int l = 0; l < LANES; l++) begin
            if (l == 0 || wide) begin
                s              = addr + AW'(l);
                wr_bytes[s]    = wr_bytes[s] | wdata[8*l +: 8];
                rdata[8*l +: 8] = rd_bank[s];
            end
        end
    end
endmodule

// File: rtl/sgi_src_bank.sv
// Source bytes and pending flags of one destination CPU.
// Order within a cycle: pending-port write first, then the generate write.
module sgi_src_bank #(
    parameter int NUM_SGI = 16,
    localparam int AW = $clog2(NUM_SGI)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    gen_hit,
    input  logic [AW-1:0]           gen_id,
    input  logic [7:0]              gen_bit,
    input  logic                    wr_hit,
    input  logic                    wr_set,
    input  logic [NUM_SGI-1:0][7:0] wr_bytes,
    output logic [NUM_SGI-1:0][7:0] src,
    output logic [NUM_SGI-1:0]      pend
);
    logic [NUM_SGI-1:0][7:0] src_d;
    logic [NUM_SGI-1:0]      pend_d;
    logic [7:0]              b;
    logic                    p;

    // Next state of every byte and flag for this CPU.
    always_comb begin
        b = '0;
        p = 1'b0;
        for (int s = 0; s < NUM_SGI; s++) begin
            b = src[s];
            p = pend[s];
            if (wr_hit) begin
                if (wr_set) begin
                    b = b | wr_bytes[s];
                    p = p | (b != 8'd0);
                end else begin
                    b = b & ~wr_bytes[s];
                    p = p & (b != 8'd0);
                end
            end
            if (gen_hit && gen_id == AW'(s)) begin
                b = b | gen_bit;
                p = 1'b1;
            end
            src_d[s]  = b;
            pend_d[s] = p;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= '0;
            pend <= '0;
        end else begin
            src  <= src_d;
            pend <= pend_d;
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Software-generated interrupt dispatcher top.
// Assumes gen_cpu is below online_cnt and online_cnt is within 1..NUM_CPU.
module sgi_dispatch #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    parameter int LANES   = 4,
    localparam int CW  = $clog2(NUM_CPU),
    localparam int CNW = CW + 1,
    localparam int AW  = $clog2(NUM_SGI),
    localparam int DW  = 8 * LANES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNW-1:0]             online_cnt,
    input  logic                       gen_we,
    input  logic [CW-1:0]              gen_cpu,
    input  logic [31:0]                gen_word,
    input  logic                       pnd_we,
    input  logic                       pnd_set,
    input  logic                       pnd_wide,
    input  logic [CW-1:0]              pnd_cpu,
    input  logic [AW-1:0]              pnd_addr,
    input  logic [DW-1:0]              pnd_wdata,
    output logic [DW-1:0]              pnd_rdata,
    output logic [NUM_CPU*NUM_SGI-1:0] pend_o
);
    logic [NUM_CPU-1:0]                   targets;
    logic [AW-1:0]                        sgi_id;
    logic [7:0]                           req_bit;
    logic [NUM_SGI-1:0][7:0]              wr_bytes;
    logic [NUM_CPU-1:0][NUM_SGI-1:0][7:0] src_all;

    assign req_bit = 8'(1) << gen_cpu;

    sgi_target_decode #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_dec (
        .gen_word   (gen_word),
        .req_cpu    (gen_cpu),
        .online_cnt (online_cnt),
        .targets    (targets),
        .sgi_id     (sgi_id)
    );

    sgi_lane_map #(.NUM_SGI(NUM_SGI), .LANES(LANES)) u_lanes (
        .addr     (pnd_addr),
        .wide     (pnd_wide),
        .wdata    (pnd_wdata),
        .rd_bank  (src_all[pnd_cpu]),
        .wr_bytes (wr_bytes),
        .rdata    (pnd_rdata)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        sgi_src_bank #(.NUM_SGI(NUM_SGI)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_hit  (gen_we && targets[c]),
            .gen_id   (sgi_id),
            .gen_bit  (req_bit),
            .wr_hit   (pnd_we && pnd_cpu == CW'(c)),
            .wr_set   (pnd_set),
            .wr_bytes (wr_bytes),
            .src      (src_all[c]),
            .pend     (pend_o[c*NUM_SGI +: NUM_SGI])
        );
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
// Port-level properties of the dispatcher, bound to every instance.
module sgi_dispatch_chk #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CW  = $clog2(NUM_CPU),
    localparam int CNW = CW + 1,
    localparam int AW  = $clog2(NUM_SGI)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [CNW-1:0]             online_cnt,
    input logic                       gen_we,
    input logic [CW-1:0]              gen_cpu,
    input logic [31:0]                gen_word,
    input logic                       pnd_we,
    input logic                       pnd_set,
    input logic                       pnd_wide,
    input logic [CW-1:0]              pnd_cpu,
    input logic [AW-1:0]              pnd_addr,
    input logic [31:0]                pnd_wdata,
    input logic [31:0]                pnd_rdata,
    input logic [NUM_CPU*NUM_SGI-1:0] pend_o
);
    logic [NUM_CPU-1:0] om;
    logic [1:0]         mode;
    int                 gen_idx;
    int                 rd_idx;
    logic               unused_ck;

    // Online mask rebuilt independently of the decoder.
    always_comb begin
        for (int i = 0; i < NUM_CPU; i++) om[i] = (CNW'(i) < online_cnt);
    end

    assign mode      = gen_word[25:24];
    assign gen_idx   = int'(gen_cpu) * NUM_SGI + int'(gen_word[AW-1:0]);
    assign rd_idx    = int'(pnd_cpu) * NUM_SGI + int'(pnd_addr);
    assign unused_ck = ^{gen_word, pnd_wdata};

    // R5
    reserved_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_we && mode == 2'd3 && !pnd_we |=> $stable(pend_o));
    // R6
    offline_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_we && mode == 2'd0 && (gen_word[16 +: NUM_CPU] & om) == '0 && !pnd_we
        |=> $stable(pend_o));
    // R4
    self_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_we && mode == 2'd2 && om[gen_cpu] |=> pend_o[$past(gen_idx)]);
    // R3
    others_skip_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_we && mode == 2'd1 && !pnd_we |=> pend_o[$past(gen_idx)] == $past(pend_o[gen_idx]));
    // R8
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pnd_we && !pnd_set && !pnd_wide && pnd_wdata[7:0] == 8'hFF && !gen_we
        |=> !pend_o[$past(rd_idx)]);
    // R9
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pnd_wide |-> pnd_rdata[31:8] == 24'd0);
    // R7
    flag_matches_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pnd_wide |-> (pnd_rdata[7:0] != 8'd0) == pend_o[rd_idx]);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_chk (
    .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt), .gen_we(gen_we),
    .gen_cpu(gen_cpu), .gen_word(gen_word), .pnd_we(pnd_we), .pnd_set(pnd_set),
    .pnd_wide(pnd_wide), .pnd_cpu(pnd_cpu), .pnd_addr(pnd_addr),
    .pnd_wdata(pnd_wdata), .pnd_rdata(pnd_rdata), .pend_o(pend_o)
);

// File: tb/test_sgi_dispatch.sv
`timescale 1ns/1ps
module test_sgi_dispatch;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   online_cnt = 4'd4;
    logic         gen_we = 1'b0;
    logic [2:0]   gen_cpu = '0;
    logic [31:0]  gen_word = '0;
    logic         pnd_we = 1'b0, pnd_set = 1'b0, pnd_wide = 1'b0;
    logic [2:0]   pnd_cpu = '0;
    logic [3:0]   pnd_addr = '0;
    logic [31:0]  pnd_wdata = '0;
    logic [31:0]  pnd_rdata;
    logic [127:0] pend_o;

    typedef struct {
        bit           is_read;
        string        tag;
        logic [127:0] pexp;
        logic [31:0]  rexp;
    } item_t;

    item_t      q[$];
    int         checks = 0;
    int         errs = 0;
    logic [7:0] m [8][16];

    sgi_dispatch i_sgi_dispatch (.*);

    always #10 clk = ~clk;

    function automatic logic [127:0] pend_model();
        logic [127:0] v;
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 16; s++) v[c*16+s] = (m[c][s] != 8'd0);
        return v;
    endfunction

    // Monitor: pop expected items at the falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.is_read) begin
                    if (pnd_rdata !== it.rexp) begin
                        errs++;
                        $display("FAIL %s rdata actual=%h expected=%h", it.tag, pnd_rdata, it.rexp);
                    end
                end else if (pend_o !== it.pexp) begin
                    errs++;
                    $display("FAIL %s pend actual=%h expected=%h", it.tag, pend_o, it.pexp);
                end
            end
        end
    end

    task automatic push_pend(string tag);
        item_t it;
        it.is_read = 1'b0; it.tag = tag; it.pexp = pend_model(); it.rexp = '0;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    // Driver: one cycle with optional generate and pending-port writes.
    task automatic step(bit g, int req, int id, logic [7:0] list, int mode,
                        bit p, int cpu, bit set, bit wide, int addr,
                        logic [31:0] data, string tag);
        logic [7:0] om, t;
        @(negedge clk);
        gen_we = g; gen_cpu = 3'(req);
        gen_word = {6'd0, 2'(mode), list, 12'd0, 4'(id)};
        pnd_we = p; pnd_set = set; pnd_wide = wide; pnd_cpu = 3'(cpu);
        pnd_addr = 4'(addr); pnd_wdata = data;
        @(posedge clk);
        #1 gen_we = 1'b0; pnd_we = 1'b0;
        if (p) begin
            for (int l = 0; l < (wide ? 4 : 1); l++) begin
                int s = (addr + l) % 16;
                if (set) m[cpu][s] = m[cpu][s] | data[8*l +: 8];
                else     m[cpu][s] = m[cpu][s] & ~data[8*l +: 8];
            end
        end
        if (g) begin
            om = (online_cnt >= 4'd8) ? 8'hFF : 8'((1 << online_cnt) - 1);
            case (mode)
                0: t = list & om;
                1: t = om & ~(8'd1 << req);
                2: t = (8'd1 << req) & om;
                default: t = 8'd0;
            endcase
            for (int c = 0; c < 8; c++)
                if (t[c]) m[c][id] = m[c][id] | (8'd1 << req);
        end
        push_pend(tag);
    endtask

    task automatic gen(int req, int id, logic [7:0] list, int mode, string tag);
        step(1, req, id, list, mode, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic pnd(int cpu, bit set, bit wide, int addr, logic [31:0] data, string tag);
        step(0, 0, 0, 0, 0, 1, cpu, set, wide, addr, data, tag);
    endtask

    task automatic rd(int cpu, bit wide, int addr, string tag);
        item_t it;
        @(negedge clk);
        pnd_cpu = 3'(cpu); pnd_wide = wide; pnd_addr = 4'(addr);
        #1;
        it.is_read = 1'b1; it.tag = tag; it.pexp = '0; it.rexp = '0;
        for (int l = 0; l < (wide ? 4 : 1); l++) it.rexp[8*l +: 8] = m[cpu][(addr + l) % 16];
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #4_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        for (int c = 0; c < 8; c++) for (int s = 0; s < 16; s++) m[c][s] = 8'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_pend("R1");
        rd(5, 1, 0, "R1");
        // R2 and R6: list 0xFF with four CPUs online
        gen(1, 3, 8'hFF, 0, "R2");
        rd(2, 1, 0, "R9");
        // R3 and R11: second sender to the same interrupt
        gen(2, 3, 8'h00, 1, "R3");
        rd(0, 0, 3, "R11");
        gen(0, 5, 8'h00, 2, "R4");
        gen(1, 7, 8'hFF, 3, "R5");
        gen(0, 8, 8'hF0, 0, "R6");
        // R8: partial clears of a two-sender byte
        pnd(0, 0, 0, 3, 32'h02, "R8");
        rd(0, 0, 3, "R8");
        pnd(0, 0, 0, 3, 32'h04, "R8");
        // R7 and R9: wide set with wrap, zero lanes untouched
        pnd(1, 1, 1, 14, 32'h0080_0041, "R7");
        rd(1, 1, 14, "R9");
        pnd(1, 1, 0, 2, 32'h0, "R7");
        rd(1, 0, 14, "R9");
        // R12: write to bank 6 leaves others alone
        pnd(6, 1, 1, 4, 32'h1122_3344, "R12");
        rd(2, 1, 4, "R12");
        // R10: clear and generate on the same edge
        pnd(3, 1, 0, 9, 32'h01, "R10");
        step(1, 3, 9, 8'h00, 2, 1, 3, 0, 0, 9, 32'hFF, "R10");
        rd(3, 0, 9, "R10");
        // R2 and R6 with all eight CPUs online
        online_cnt = 4'd8;
        gen(7, 0, 8'h81, 0, "R2");
        rd(7, 1, 0, "R2");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule